// File: doc/BRIEF.md
# Quadrature Position Counter with Count and Wrap Strobes

This block turns a pair of quadrature signals, A and B, into a signed-direction position count. Both inputs pass through a two-stage synchroniser. Each new sample is compared with the previous one, and a decoded step is produced according to the resolution chosen on the mode input: every edge of either channel, every edge of A alone, or one particular edge of A per signal period. A 32-bit counter then moves up or down by one for each decoded step.

Alongside the counter the block drives three outputs. A direction level shows the sense of the most recent step. A count strobe marks each step. A wrap strobe marks each step that carries the counter across its end, from all ones to zero or from zero to all ones. Each strobe is a pulse half a clock long that occupies the low phase of the cycle in which the counter takes its new value. The direction level is registered one cycle before that update cycle, so it settles early and holds steady through the strobe. A downstream counter can take the strobes and the direction level as a clock and an up/down control.

Top module: `quad_count_pulse`

## Requirements
- R1: While rst_n is low, count, dir, cnt_strobe and wrap_strobe are all 0, whatever state came before.
- R2: With mode = 2'b10 (and also with 2'b11), every single-channel change of the synchronised (A,B) pair is one step. A step is up (count +1, dir = 1) on 00→10→11→01→00 and down (count -1, dir = 0) on the reverse order.
- R3: With mode = 2'b01, only changes of A are steps. Changes of B alone leave count and dir unchanged. Direction follows the rule in R2.
- R4: With mode = 2'b00, a step is a change of A while B is low. A rising is up, A falling is down. All other changes leave count unchanged.
- R5: A sample in which A and B both change produces no step, and count and dir keep their values.
- R6: After an input change that lands before rising edge X, dir takes its new level at edge X+2 and count takes its new value at edge X+3.
- R7: cnt_strobe is high only during the low clock phase of the cycle that begins at the edge where count changes, and it gives exactly one pulse per step.
- R8: dir holds the level of a step from one full clock cycle before the rising edge of its strobe until one full clock cycle after it. This needs input changes at least 3 clock cycles apart.
- R9: The counter wraps modulo 2^32. wrap_strobe pulses alongside cnt_strobe only when an up step moves count from all ones to 0, or a down step moves it from 0 to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; strobes use its low phase |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Resolution: 00 one step per period, 01 A edges, 10/11 all edges |
| in_a | input | 1 | Quadrature channel A, asynchronous |
| in_b | input | 1 | Quadrature channel B, asynchronous |
| count | output | 32 | Position counter |
| dir | output | 1 | Direction of the latest step, 1 = up |
| cnt_strobe | output | 1 | Half-cycle pulse for each step |
| wrap_strobe | output | 1 | Half-cycle pulse for each counter wrap |

## Verification
The assertions on direction set-up and hold assume that decoded steps come at least three clock cycles apart. They also assume that A and B are low when reset is released, so that the synchroniser and the previous-sample register agree with the inputs from the start. The stimulus drives every input change at a falling edge and then holds the new level for six clocks, and it returns both channels to low before each reset. The illegal-transition check relies on changing both channels at the same falling edge, so both changes land in one sample.

// File: rtl/quad_count_pulse.sv
module quad_count_pulse #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          in_a,
  input  logic          in_b,
  output logic [CW-1:0] count,
  output logic          dir,
  output logic          cnt_strobe,
  output logic          wrap_strobe
);

  logic [1:0] sync_a, sync_b;
  logic       prev_a, prev_b;
  logic       step_q, up_q;
  logic       cnt_pulse, wrap_pulse;

  wire a  = sync_a[1];
  wire b  = sync_b[1];
  wire da = a ^ prev_a;
  wire db = b ^ prev_b;

  wire edge_any = da ^ db;
  wire edge_a   = da & ~db;
  wire edge_one = edge_a & ~b;
  wire step     = (mode == 2'b00) ? edge_one :
                  (mode == 2'b01) ? edge_a   : edge_any;
  wire up       = da ? (a ^ b) : ~(a ^ b);
  wire at_end   = up_q ? (&count) : (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
      prev_a <= 1'b0;
      prev_b <= 1'b0;
    end else begin
      sync_a <= {sync_a[0], in_a};
      sync_b <= {sync_b[0], in_b};
      prev_a <= a;
      prev_b <= b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= 1'b0;
      up_q   <= 1'b0;
      dir    <= 1'b0;
    end else begin
      step_q <= step;
      if (step) begin
        up_q <= up;
        dir  <= up;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count      <= '0;
      cnt_pulse  <= 1'b0;
      wrap_pulse <= 1'b0;
    end else begin
      cnt_pulse  <= step_q;
      wrap_pulse <= step_q & at_end;
      if (step_q) count <= up_q ? count + 1'b1 : count - 1'b1;
    end
  end

  assign cnt_strobe  = cnt_pulse & ~clk;
  assign wrap_strobe = wrap_pulse & ~clk;

  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_pulse |-> (count - $past(count)) == (dir ? CW'(1) : {CW{1'b1}})); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_pulse |-> $stable(count)); // R7
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (da && db) |=> ##1 !cnt_pulse); // R5
  AST_DIR_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_pulse |-> $stable(dir)); // R8
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt_pulse) |-> $stable(dir)); // R8
  AST_WRAP_WITH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |-> cnt_pulse); // R9
  AST_WRAP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |-> ((dir && count == '0) || (!dir && (&count)))); // R9

endmodule

// File: tb/sim_quad_count_pulse.sv
`timescale 1ns/1ps
module sim_quad_count_pulse;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b10;
  logic        in_a = 1'b0, in_b = 1'b0;
  logic [31:0] count;
  logic        dir, cnt_strobe, wrap_strobe;
  int n_chk = 0, n_bad = 0, n_cnt = 0, n_wrap = 0;
  logic [31:0] exp_cnt = '0;

  quad_count_pulse u0 (.clk(clk), .rst_n(rst_n), .mode(mode), .in_a(in_a),
    .in_b(in_b), .count(count), .dir(dir), .cnt_strobe(cnt_strobe),
    .wrap_strobe(wrap_strobe));

  always #2.5 clk = ~clk;
  always @(posedge cnt_strobe) n_cnt++;
  always @(posedge wrap_strobe) n_wrap++;

  // {mode[1:0], a, b, delta[1:0] (01 +1, 11 -1, 00 none), dir}
  localparam int NV = 23;
  localparam logic [6:0] VEC [0:NV-1] = '{
    7'b10_1_0_01_1, 7'b10_1_1_01_1, 7'b10_0_1_01_1, 7'b10_0_0_01_1,
    7'b10_0_1_11_0, 7'b10_1_1_11_0, 7'b10_1_0_11_0, 7'b10_0_0_11_0,
    7'b01_1_0_01_1, 7'b01_1_1_00_1, 7'b01_0_1_01_1, 7'b01_0_0_00_1,
    7'b00_1_0_01_1, 7'b00_1_1_00_1, 7'b00_0_1_00_1, 7'b00_0_0_00_1,
    7'b00_0_1_00_1, 7'b00_1_1_00_1, 7'b00_1_0_00_1, 7'b00_0_0_11_0,
    7'b10_1_1_00_0, 7'b10_0_0_00_0, 7'b11_1_0_01_1
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 count", count, 0);
    chk("R1 dir", {31'b0, dir}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      int c0;
      logic [1:0] d;
      c0 = n_cnt;
      mode = VEC[i][6:5]; in_a = VEC[i][4]; in_b = VEC[i][3];
      d = VEC[i][2:1];
      repeat (6) @(negedge clk);
      if (d == 2'b01) exp_cnt = exp_cnt + 1;
      else if (d == 2'b11) exp_cnt = exp_cnt - 1;
      chk($sformatf("R2/R3/R4/R5 vec%0d count", i), count, exp_cnt);
      chk($sformatf("R2/R3/R4/R5 vec%0d dir", i), {31'b0, dir}, {31'b0, VEC[i][0]});
      chk($sformatf("R7 vec%0d pulses", i), n_cnt - c0, (d == 2'b00) ? 0 : 1);
    end
    chk("R9 no wrap in table", n_wrap, 0);

    // R6 R7 R8 timing: state (1,0), 4x mode; A falls -> down step
    mode = 2'b10;
    in_a = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R8 dir before change", {31'b0, dir}, 1);
    @(posedge clk); #1;
    chk("R6 dir at X+2", {31'b0, dir}, 0);
    chk("R6 count at X+2", count, exp_cnt);
    #2.5 chk("R7 strobe low before update", {31'b0, cnt_strobe}, 0);
    @(posedge clk); #1;
    exp_cnt = exp_cnt - 1;
    chk("R6 count at X+3", count, exp_cnt);
    chk("R7 strobe low in high phase", {31'b0, cnt_strobe}, 0);
    #2.5 chk("R7 strobe high in low phase", {31'b0, cnt_strobe}, 1);
    chk("R8 dir at strobe rise", {31'b0, dir}, 0);
    @(posedge clk); #1;
    chk("R8 dir held after strobe", {31'b0, dir}, 0);
    #2.5 chk("R7 strobe gone next cycle", {31'b0, cnt_strobe}, 0);
    repeat (4) @(negedge clk);

    // R1 reset from nonzero state, then R9 wrap both ways
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 count cleared", count, 0);
    chk("R1 strobes", {30'b0, cnt_strobe, wrap_strobe}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    begin
      int w0;
      w0 = n_wrap;
      in_b = 1'b1;
      repeat (6) @(negedge clk);
      chk("R9 underflow value", count, 32'hFFFF_FFFF);
      chk("R9 underflow wrap", n_wrap - w0, 1);
      in_b = 1'b0;
      repeat (6) @(negedge clk);
      chk("R9 overflow value", count, 0);
      chk("R9 overflow wrap", n_wrap - w0, 2);
      chk("R9 overflow dir", {31'b0, dir}, 1);
      in_a = 1'b1;
      repeat (6) @(negedge clk);
      chk("R9 no wrap on plain step", n_wrap - w0, 2);
      chk("R2 plain step", count, 1);
    end
    finish_run();
  end
endmodule